// File: doc/BRIEF.md
# I2C Master SCL Bit-Phase Timer

This block sits between the configuration of an I2C master and its bit engine. From the system clock and a programmable 16-bit baud count, it produces the timing of each SCL period as single-cycle strobes. One strobe marks the moment SCL is to be pulled low, which is the start of a period. The other marks the moment SCL is to be released. The block also drives a level that says whether the master is currently holding SCL low. The period holds two baud counts in standard mode and three baud counts in fast or fast-plus mode. In the three-count case, two counts are low and one is high.

A slave may hold SCL low during the high phase to stretch the clock. While it does, the block freezes its count. Once the line is seen high again, the block waits a programmable number of setup cycles and pulses a setup-done strobe. It then finishes the rest of the high phase. The bit engine uses that strobe to time data after a stretch.

Configuration is sampled only at the boundary between SCL periods. A period that has begun always completes with the timing it started with. A baud count of zero parks the block with SCL released.

Top module: `scl_rate_timer`

## Requirements
- R1: While reset is high and after it, until the first period starts, `scl_low`, `tick_fall`, `tick_rise` and `setup_done` are all 0. Reset is synchronous.
- R2: With `cfg_speed` = 0 (standard) and baud B > 0, `tick_rise` pulses B cycles after `tick_fall`, and the next `tick_fall` follows 2·B cycles after the previous one. `scl_low` is 1 from a fall tick until the rise tick, and 0 from the rise tick until the next fall tick.
- R3: With `cfg_speed` = 1, 2 or 3 (fast modes), `tick_rise` pulses 2·B cycles after `tick_fall`, and the period is 3·B cycles.
- R4: A change of `cfg_baud` in the middle of a period does not alter that period. The new count governs from the next `tick_fall`.
- R5: A change of `cfg_speed` in the middle of a period does not alter that period. The new count split governs from the next `tick_fall`.
- R6: If `cfg_baud` is 0 at a period boundary, no further ticks occur and `scl_low` stays 0. When the block is idle and `scl_in` is high, a nonzero `cfg_baud` produces `tick_fall` on the next clock edge.
- R7: During the high phase, a low `scl_in` freezes the phase count. No `tick_fall` occurs while SCL is held low by another device.
- R8: Let the clock edge on which a released `scl_in` is first sampled high be E, and let S be the setup count latched at the start of the period. `setup_done` pulses S edges after E, which is on E itself when S = 0. The next `tick_fall` comes B edges after `setup_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_speed | input | 2 | Speed mode: 0 standard, any other value fast |
| cfg_baud | input | BAUD_W | Baud count per phase slot; 0 stops the clock |
| cfg_setup | input | SETUP_W | Setup cycles after a clock stretch ends |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_low | output | 1 | Master holds SCL low |
| tick_fall | output | 1 | One-cycle strobe: start of a period, pull SCL low |
| tick_rise | output | 1 | One-cycle strobe: release SCL for the high phase |
| setup_done | output | 1 | One-cycle strobe: setup time after a stretch has elapsed |

## Verification
The bench sweeps every speed code against small baud counts, down to a baud of 1. A design that counts off-by-one would show shifted tick distances at every baud value, and a wrong slot split would put the rise at the wrong point. It stretches the clock for each setup count from 0 to 3. This catches a setup counter that treats 0 like 1, and a phase count that keeps running under the stretch, which would make the fall arrive early. Configuration changes made in the middle of a period catch a design that uses the live inputs instead of the latched ones. The zero-baud test catches a block that keeps ticking, or that does not restart immediately once a count returns.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_SETUP = 2'd3
    } scl_state_e;

    localparam int DEF_BAUD_W  = 16;
    localparam int DEF_SETUP_W = 8;
    localparam int SLOT_W      = 2;

    // any non-standard speed code uses the three-slot period
    function automatic logic speed_is_fast(input logic [1:0] speed);
        return |speed;
    endfunction

    // index of the single high slot in a period
    function automatic logic [SLOT_W-1:0] high_slot(input logic fast);
        return fast ? SLOT_W'(2) : SLOT_W'(1);
    endfunction

endpackage

// File: rtl/scl_slot_counter.sv
module scl_slot_counter #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic [BAUD_W-1:0] baud,
    output logic              slot_end
);
    logic [BAUD_W-1:0] cnt;

    assign slot_end = (cnt == BAUD_W'(baud - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= slot_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_setup_delay.sv
module scl_setup_delay #(
    parameter int SETUP_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [SETUP_W-1:0] len,
    output logic               done
);
    logic               busy;
    logic [SETUP_W-1:0] cnt;

    always_comb begin
        if (start) begin
            done = (len == '0);
        end else begin
            done = busy && (cnt == SETUP_W'(len - 1'b1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= (len != '0);
            cnt  <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
    parameter int BAUD_W  = 16,
    parameter int SETUP_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BAUD_W-1:0]  in_baud,
    input  logic               in_fast,
    input  logic [SETUP_W-1:0] in_setup,
    output logic [BAUD_W-1:0]  act_baud,
    output logic               act_fast,
    output logic [SETUP_W-1:0] act_setup
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act_baud  <= '0;
            act_fast  <= 1'b0;
            act_setup <= '0;
        end else if (load) begin
            act_baud  <= in_baud;
            act_fast  <= in_fast;
            act_setup <= in_setup;
        end
    end
endmodule

// File: rtl/scl_rate_timer.sv
module scl_rate_timer
    import scl_timer_pkg::*;
#(
    parameter int BAUD_W  = DEF_BAUD_W,
    parameter int SETUP_W = DEF_SETUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_speed,
    input  logic [BAUD_W-1:0]  cfg_baud,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic               scl_in,
    output logic               scl_low,
    output logic               tick_fall,
    output logic               tick_rise,
    output logic               setup_done
);
    scl_state_e        st;
    logic [SLOT_W-1:0] slot;
    logic [BAUD_W-1:0] act_baud;
    logic              act_fast;
    logic [SETUP_W-1:0] act_setup;
    logic              slot_end;
    logic              in_high;
    logic              hold_now;
    logic              run_en;
    logic              boundary;
    logic              load;
    logic              sd_start;
    logic              sd_done;

    always_comb begin
        in_high  = (slot == high_slot(act_fast));
        hold_now = (st == ST_RUN) && in_high && !scl_in;
        run_en   = (st == ST_RUN) && !hold_now;
        boundary = run_en && slot_end && in_high;
        load     = ((st == ST_IDLE) && (cfg_baud != '0) && scl_in)
                || (boundary && (cfg_baud != '0));
        sd_start = (st == ST_HOLD) && scl_in;
    end

    scl_cfg_shadow #(.BAUD_W(BAUD_W), .SETUP_W(SETUP_W)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .in_baud   (cfg_baud),
        .in_fast   (speed_is_fast(cfg_speed)),
        .in_setup  (cfg_setup),
        .act_baud  (act_baud),
        .act_fast  (act_fast),
        .act_setup (act_setup)
    );

    scl_slot_counter #(.BAUD_W(BAUD_W)) u_slot_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (run_en),
        .clr      (load),
        .baud     (act_baud),
        .slot_end (slot_end)
    );

    scl_setup_delay #(.SETUP_W(SETUP_W)) u_setup (
        .clk   (clk),
        .rst   (rst),
        .start (sd_start),
        .len   (act_setup),
        .done  (sd_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            slot       <= '0;
            scl_low    <= 1'b0;
            tick_fall  <= 1'b0;
            tick_rise  <= 1'b0;
            setup_done <= 1'b0;
        end else begin
            tick_fall  <= 1'b0;
            tick_rise  <= 1'b0;
            setup_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (load) begin
                        st        <= ST_RUN;
                        slot      <= '0;
                        scl_low   <= 1'b1;
                        tick_fall <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (hold_now) begin
                        st <= ST_HOLD;
                    end else if (slot_end) begin
                        if (in_high) begin
                            slot <= '0;
                            if (load) begin
                                scl_low   <= 1'b1;
                                tick_fall <= 1'b1;
                            end else begin
                                st      <= ST_IDLE;
                                scl_low <= 1'b0;
                            end
                        end else begin
                            slot <= slot + 1'b1;
                            if (SLOT_W'(slot + 1'b1) == high_slot(act_fast)) begin
                                scl_low   <= 1'b0;
                                tick_rise <= 1'b1;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (sd_start) begin
                        if (sd_done) begin
                            st         <= ST_RUN;
                            setup_done <= 1'b1;
                        end else begin
                            st <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: begin
                    if (sd_done) begin
                        st         <= ST_RUN;
                        setup_done <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scl_rate_timer_chk.sv
module scl_rate_timer_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic scl_low,
    input logic tick_fall,
    input logic tick_rise,
    input logic setup_done
);
    // R2 R3: a period is at least two cycles, so falls never repeat back to back
    fall_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_fall |=> !tick_fall);

    // R7
    no_fall_while_stretched_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_low && !scl_in) |=> !tick_fall);

    // R8
    setup_released_chk: assert property (@(posedge clk) disable iff (rst)
        setup_done |-> !scl_low);

    // R2 R8
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tick_fall, tick_rise, setup_done}));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !(tick_rise || setup_done));
endmodule

bind scl_rate_timer scl_rate_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl_in),
    .scl_low    (scl_low),
    .tick_fall  (tick_fall),
    .tick_rise  (tick_rise),
    .setup_done (setup_done)
);

// File: tb/tb_scl_rate_timer.sv
`timescale 1ns/1ps
module tb_scl_rate_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_speed = 2'd0;
    logic [15:0] cfg_baud = 16'd0;
    logic [7:0]  cfg_setup = 8'd0;
    logic        slave_hold = 1'b0;
    logic        scl_in;
    logic        scl_low, tick_fall, tick_rise, setup_done;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;

    assign scl_in = !(scl_low || slave_hold);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_rate_timer dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_speed  (cfg_speed),
        .cfg_baud   (cfg_baud),
        .cfg_setup  (cfg_setup),
        .scl_in     (scl_in),
        .scl_low    (scl_low),
        .tick_fall  (tick_fall),
        .tick_rise  (tick_rise),
        .setup_done (setup_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // which: 0 fall, 1 rise, 2 setup_done
    task automatic wait_ev(input int which, output int t);
        t = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if ((which == 0 && tick_fall) || (which == 1 && tick_rise) ||
                (which == 2 && setup_done)) begin
                t = cyc;
                return;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int t0, t1, t2, t3, t4, tr, ts, tf, e0, k;
        bit bad;

        // R1: reset state and idle with zero baud
        repeat (2) @(negedge clk);
        chk({scl_low, tick_fall, tick_rise, setup_done} == 4'b0, "R1",
            {scl_low, tick_fall, tick_rise, setup_done}, 0);
        rst = 1'b0;
        bad = 0;
        repeat (10) begin
            @(negedge clk);
            if (scl_low || tick_fall || tick_rise || setup_done) bad = 1;
        end
        chk(!bad, "R1", bad, 0);

        // R2 / R3: period sweep over speed codes and baud values
        for (int sp = 0; sp < 4; sp++) begin
            for (int b = 1; b <= 6; b++) begin
                string rq;
                int n;
                rq = (sp == 0) ? "R2" : "R3";
                n  = (sp == 0) ? 2 : 3;
                cfg_speed = 2'(sp);
                cfg_baud  = 16'(b);
                do_reset();
                wait_ev(0, t0);
                chk(scl_low == 1'b1, rq, scl_low, 1);
                wait_ev(1, t1);
                chk(t1 - t0 == (n - 1) * b, rq, t1 - t0, (n - 1) * b);
                chk(scl_low == 1'b0, rq, scl_low, 0);
                wait_ev(0, t2);
                chk(t2 - t0 == n * b, rq, t2 - t0, n * b);
            end
        end

        // R7 / R8: stretch with each setup count
        for (int sp = 0; sp < 2; sp++) begin
            for (int b = 1; b <= 4; b++) begin
                for (int s = 0; s < 4; s++) begin
                    cfg_speed  = 2'(sp);
                    cfg_baud   = 16'(b);
                    cfg_setup  = 8'(s);
                    slave_hold = 1'b0;
                    do_reset();
                    wait_ev(0, t0);
                    slave_hold = 1'b1;
                    wait_ev(1, tr);
                    bad = 0;
                    repeat (6) begin
                        @(negedge clk);
                        if (tick_fall || setup_done) bad = 1;
                    end
                    chk(!bad, "R7", bad, 0);
                    slave_hold = 1'b0;
                    e0 = cyc + 1;
                    wait_ev(2, ts);
                    chk(ts == e0 + s, "R8", ts - e0, s);
                    wait_ev(0, tf);
                    chk(tf == ts + b, "R7", tf - ts, b);
                end
            end
        end

        // R4: baud change mid-period
        cfg_speed = 2'd0;
        cfg_baud  = 16'd3;
        cfg_setup = 8'd0;
        do_reset();
        wait_ev(0, t0);
        @(negedge clk);
        cfg_baud = 16'd5;
        wait_ev(1, t1);
        chk(t1 - t0 == 3, "R4", t1 - t0, 3);
        wait_ev(0, t2);
        chk(t2 - t0 == 6, "R4", t2 - t0, 6);
        wait_ev(1, t3);
        chk(t3 - t2 == 5, "R4", t3 - t2, 5);
        wait_ev(0, t4);
        chk(t4 - t2 == 10, "R4", t4 - t2, 10);

        // R5: speed change mid-period
        cfg_speed = 2'd0;
        cfg_baud  = 16'd2;
        do_reset();
        wait_ev(0, t0);
        cfg_speed = 2'd1;
        wait_ev(1, t1);
        chk(t1 - t0 == 2, "R5", t1 - t0, 2);
        wait_ev(0, t2);
        chk(t2 - t0 == 4, "R5", t2 - t0, 4);
        wait_ev(1, t3);
        chk(t3 - t2 == 4, "R5", t3 - t2, 4);
        wait_ev(0, t4);
        chk(t4 - t2 == 6, "R5", t4 - t2, 6);

        // R6: zero baud stops at the boundary, then restart
        cfg_speed = 2'd0;
        cfg_baud  = 16'd3;
        do_reset();
        wait_ev(0, t0);
        cfg_baud = 16'd0;
        wait_ev(1, t1);
        chk(t1 - t0 == 3, "R6", t1 - t0, 3);
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (tick_fall || tick_rise || scl_low) bad = 1;
        end
        chk(!bad, "R6", bad, 0);
        cfg_baud = 16'd2;
        k = cyc;
        wait_ev(0, t2);
        chk(t2 == k + 1, "R6", t2 - k, 1);
        wait_ev(1, t3);
        chk(t3 - t2 == 2, "R6", t3 - t2, 2);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule